// File: doc/BRIEF.md
# Aliased floating-point register file

This block holds the floating-point architectural registers of a processor core as a flat array of 32-bit words. Every access names a precision: single (one word), double (two consecutive words) or quad (four consecutive words). A double or quad is therefore an alias of the singles that lie under it. A write of one precision is seen at once by reads of the other precisions over the same words. A parameter selects either a 32-word file or a 64-word file.

There are two read ports and one write port. Each port takes a 2-bit precision code and the raw 5-bit register field taken from the instruction word. Destination fields sit at instruction bits 29:25 and source fields at bits 18:14 and 4:0; the decoder that slices them out lives in the neighbouring logic. In the 64-word file the 5-bit field cannot name a word above 31 directly. For double and quad accesses, the lowest field bit is therefore moved to the top of a 6-bit word index. Reads are combinational. Writes take effect at the rising clock edge.

Top module: `fpr_alias_file`

## Requirements
- R1: After reset, every word of the file reads as zero at every precision. Reset is asserted asynchronously (rst_n low). The file accepts writes from the third rising edge after rst_n is released.
- R2: Precision code 0 selects a single access to one word. The word is carried in data bits 31:0, and read data bits 127:32 are zero.
- R3: Precision code 1 selects a double access at base index n, covering words n and n+1. Word n travels in data bits 63:32 and word n+1 in bits 31:0. Read data bits 127:64 are zero.
- R4: Precision code 2 selects a quad access at base index n, covering words n to n+3. Word n travels in bits 127:96, n+1 in 95:64, n+2 in 63:32 and n+3 in 31:0.
- R5: In the 32-word file (WIDE=0), the base index equals the field value. Field bit 0 is ignored for doubles, and field bits 1:0 are ignored for quads.
- R6: In the 64-word file (WIDE=1), a double or quad base index is built as follows: index bit 5 is field bit 0, index bits 4:1 are field bits 4:1, and index bit 0 is zero. For quads, index bit 1 is also zero.
- R7: In the 64-word file, a single access at field value f addresses word f, so singles reach only words 0 to 31.
- R8: One write updates every word it covers at a single clock edge and leaves every other word unchanged. A single read of a word under an earlier double or quad write returns that word's part of the written value.
- R9: Both read ports are independent and combinational. A read in the cycle after a write returns the newly written data, and a read in the same cycle as a write returns the old data.
- R10: Precision code 3 is reserved. A write with it changes no word, and a read with it returns all zeros.
- R11: When wr_en is low, no word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_prec | input | 2 | Read port 0 precision code |
| rd0_fld | input | 5 | Read port 0 raw register field |
| rd0_data | output | 128 | Read port 0 data, right aligned |
| rd1_prec | input | 2 | Read port 1 precision code |
| rd1_fld | input | 5 | Read port 1 raw register field |
| rd1_data | output | 128 | Read port 1 data, right aligned |
| wr_en | input | 1 | Write enable |
| wr_prec | input | 2 | Write precision code |
| wr_fld | input | 5 | Write raw register field |
| wr_data | input | 128 | Write data, right aligned |

## Verification
The bench drives a 64-word instance and a 32-word instance in parallel. It targets odd fields at double and quad precision. If a design failed to move field bit 0 to index bit 5, a double write with field 3 would land in words 2 and 3, not in words 34 and 35. If a design failed to drop the bit in the narrow file, it would write across a pair boundary. Single reads of words under a double write expose any word-order swap inside a wide value. A reserved precision code and a low write enable are each followed by reads of the words that a faulty design would have written. A second reset in the middle of the run shows whether reset clears every word.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_LANES = 4;
  localparam int BUS_W     = WORD_W * MAX_LANES;
  localparam int FLD_W     = 5;

  typedef enum logic [1:0] {
    PREC_S   = 2'd0,
    PREC_D   = 2'd1,
    PREC_Q   = 2'd2,
    PREC_RSV = 2'd3
  } prec_e;
endpackage

// File: rtl/fpr_rst_sync.sv
module fpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fpr_idx_decode.sv
module fpr_idx_decode #(
  parameter bit WIDE = 1'b1,
  localparam int IDX_W = WIDE ? 6 : 5
) (
  input  logic [1:0]                 prec,
  input  logic [fpr_pkg::FLD_W-1:0]  fld,
  output logic [IDX_W-1:0]           base,
  output logic [2:0]                 lanes
);
  import fpr_pkg::*;

  logic [IDX_W-1:0] idx_s, idx_d, idx_q;

  generate
    if (WIDE) begin : g_wide
      assign idx_s = {1'b0, fld};
      assign idx_d = {fld[0], fld[4:1], 1'b0};
      assign idx_q = {fld[0], fld[4:2], 2'b00};
    end else begin : g_narrow
      assign idx_s = fld;
      assign idx_d = {fld[4:1], 1'b0};
      assign idx_q = {fld[4:2], 2'b00};
    end
  endgenerate

  always_comb begin
    base  = idx_s;
    lanes = 3'd0;
    unique case (prec_e'(prec))
      PREC_S:   begin base = idx_s; lanes = 3'd1; end
      PREC_D:   begin base = idx_d; lanes = 3'd2; end
      PREC_Q:   begin base = idx_q; lanes = 3'd4; end
      default:  begin base = idx_s; lanes = 3'd0; end
    endcase
  end
endmodule

// File: rtl/fpr_word_store.sv
module fpr_word_store #(
  parameter int NWORDS = 64,
  parameter int IDX_W  = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  base,
  input  logic [2:0]                        lanes,
  input  logic [fpr_pkg::BUS_W-1:0]         wr_data,
  output logic [NWORDS*fpr_pkg::WORD_W-1:0] words_flat
);
  import fpr_pkg::*;

  genvar k;
  generate
    for (k = 0; k < NWORDS; k++) begin : g_word
      logic [WORD_W-1:0] word_q, word_d;
      logic              word_en;
      int                off;

      // next-state: a word is hit when it lies inside [base, base+lanes)
      always_comb begin
        off     = k - int'(base);
        word_en = wr_en && (off >= 0) && (off < int'(lanes));
        word_d  = word_q;
        if (word_en)
          word_d = wr_data[WORD_W*(int'(lanes)-1-off) +: WORD_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (word_en) word_q <= word_d;
      end

      assign words_flat[WORD_W*k +: WORD_W] = word_q;
    end
  endgenerate
endmodule

// File: rtl/fpr_read_mux.sv
module fpr_read_mux #(
  parameter int NWORDS = 64,
  parameter int IDX_W  = 6
) (
  input  logic [NWORDS*fpr_pkg::WORD_W-1:0] words_flat,
  input  logic [IDX_W-1:0]                  base,
  input  logic [2:0]                        lanes,
  output logic [fpr_pkg::BUS_W-1:0]         data
);
  import fpr_pkg::*;

  always_comb begin
    data = '0;
    for (int j = 0; j < MAX_LANES; j++) begin
      if (j < int'(lanes))
        data[WORD_W*(int'(lanes)-1-j) +: WORD_W] =
          words_flat[WORD_W*(int'(base)+j) +: WORD_W];
    end
  end
endmodule

// File: rtl/fpr_alias_file.sv
module fpr_alias_file #(
  parameter bit WIDE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   rd0_prec,
  input  logic [4:0]   rd0_fld,
  output logic [127:0] rd0_data,
  input  logic [1:0]   rd1_prec,
  input  logic [4:0]   rd1_fld,
  output logic [127:0] rd1_data,
  input  logic         wr_en,
  input  logic [1:0]   wr_prec,
  input  logic [4:0]   wr_fld,
  input  logic [127:0] wr_data
);
  import fpr_pkg::*;

  localparam int NWORDS = WIDE ? 64 : 32;
  localparam int IDX_W  = WIDE ? 6 : 5;

  logic                     rst_sync_n;
  logic [IDX_W-1:0]         wr_base, r0_base, r1_base;
  logic [2:0]               wr_lanes, r0_lanes, r1_lanes;
  logic [NWORDS*WORD_W-1:0] words_flat;

  fpr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fpr_idx_decode #(.WIDE(WIDE)) u_dec_wr (
    .prec(wr_prec), .fld(wr_fld), .base(wr_base), .lanes(wr_lanes));
  fpr_idx_decode #(.WIDE(WIDE)) u_dec_r0 (
    .prec(rd0_prec), .fld(rd0_fld), .base(r0_base), .lanes(r0_lanes));
  fpr_idx_decode #(.WIDE(WIDE)) u_dec_r1 (
    .prec(rd1_prec), .fld(rd1_fld), .base(r1_base), .lanes(r1_lanes));

  fpr_word_store #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .base(wr_base),
    .lanes(wr_lanes), .wr_data(wr_data), .words_flat(words_flat));

  fpr_read_mux #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_rmux0 (
    .words_flat(words_flat), .base(r0_base), .lanes(r0_lanes), .data(rd0_data));
  fpr_read_mux #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_rmux1 (
    .words_flat(words_flat), .base(r1_base), .lanes(r1_lanes), .data(rd1_data));
endmodule

// File: rtl/fpr_alias_file_chk.sv
module fpr_alias_file_chk (
  input logic         clk,
  input logic         sync_rst_n,
  input logic [1:0]   rd0_prec,
  input logic [4:0]   rd0_fld,
  input logic [127:0] rd0_data,
  input logic [1:0]   rd1_prec,
  input logic [127:0] rd1_data,
  input logic         wr_en,
  input logic [1:0]   wr_prec,
  input logic [4:0]   wr_fld,
  input logic [127:0] wr_data
);
  // R10: reserved code reads zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!sync_rst_n)
    (rd1_prec == 2'd3) |-> (rd1_data == '0));

  // R2: single reads keep upper bits clear
  a_r2_single_upper_zero: assert property (@(posedge clk) disable iff (!sync_rst_n)
    (rd0_prec == 2'd0) |-> (rd0_data[127:32] == '0));

  // R3: double reads keep upper half clear
  a_r3_double_upper_zero: assert property (@(posedge clk) disable iff (!sync_rst_n)
    (rd0_prec == 2'd1) |-> (rd0_data[127:64] == '0));

  // R9: single written last cycle is read back at the same field
  a_r9_single_rw: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && $past(wr_en) && $past(wr_prec) == 2'd0 &&
     rd0_prec == 2'd0 && rd0_fld == $past(wr_fld))
    |-> (rd0_data[31:0] == $past(wr_data[31:0])));

  // R3: double written last cycle is read back whole
  a_r3_double_rw: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && $past(wr_en) && $past(wr_prec) == 2'd1 &&
     rd0_prec == 2'd1 && rd0_fld == $past(wr_fld))
    |-> (rd0_data[63:0] == $past(wr_data[63:0])));

  // R4: quad written last cycle is read back whole
  a_r4_quad_rw: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(sync_rst_n) && $past(wr_en) && $past(wr_prec) == 2'd2 &&
     rd0_prec == 2'd2 && rd0_fld == $past(wr_fld))
    |-> (rd0_data == $past(wr_data)));
endmodule

bind fpr_alias_file fpr_alias_file_chk u_chk (
  .clk(clk), .sync_rst_n(rst_sync_n),
  .rd0_prec(rd0_prec), .rd0_fld(rd0_fld), .rd0_data(rd0_data),
  .rd1_prec(rd1_prec), .rd1_data(rd1_data),
  .wr_en(wr_en), .wr_prec(wr_prec), .wr_fld(wr_fld), .wr_data(wr_data));

// File: tb/fpr_alias_file_tb.sv
module fpr_alias_file_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   rd0_prec, rd1_prec, wr_prec;
  logic [4:0]   rd0_fld, rd1_fld, wr_fld;
  logic         wr_en;
  logic [127:0] wr_data;
  logic [127:0] w_rd0, w_rd1, n_rd0, n_rd1;

  logic [31:0] mw [64];
  logic [31:0] mn [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpr_alias_file #(.WIDE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_prec(rd0_prec), .rd0_fld(rd0_fld), .rd0_data(w_rd0),
    .rd1_prec(rd1_prec), .rd1_fld(rd1_fld), .rd1_data(w_rd1),
    .wr_en(wr_en), .wr_prec(wr_prec), .wr_fld(wr_fld), .wr_data(wr_data));

  fpr_alias_file #(.WIDE(1'b0)) u_dut_nar (
    .clk(clk), .rst_n(rst_n),
    .rd0_prec(rd0_prec), .rd0_fld(rd0_fld), .rd0_data(n_rd0),
    .rd1_prec(rd1_prec), .rd1_fld(rd1_fld), .rd1_data(n_rd1),
    .wr_en(wr_en), .wr_prec(wr_prec), .wr_fld(wr_fld), .wr_data(wr_data));

  // base index from R5/R6/R7
  function automatic int base_of(bit wide, logic [1:0] p, logic [4:0] f);
    case (p)
      2'd1:    return wide ? (int'(f[0]) * 32 + int'(f[4:1]) * 2) : int'(f[4:1]) * 2;
      2'd2:    return wide ? (int'(f[0]) * 32 + int'(f[4:2]) * 4) : int'(f[4:2]) * 4;
      default: return int'(f);
    endcase
  endfunction

  function automatic int lanes_of(logic [1:0] p);
    case (p)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [127:0] model_read(bit wide, logic [1:0] p, logic [4:0] f);
    logic [127:0] r = '0;
    int n = lanes_of(p);
    int b = base_of(wide, p, f);
    for (int j = 0; j < n; j++)
      r[32*(n-1-j) +: 32] = wide ? mw[b+j] : mn[b+j];
    return r;
  endfunction

  task automatic model_write(logic [1:0] p, logic [4:0] f, logic [127:0] d);
    int n = lanes_of(p);
    int bw = base_of(1'b1, p, f);
    int bn = base_of(1'b0, p, f);
    for (int j = 0; j < n; j++) begin
      mw[bw+j] = d[32*(n-1-j) +: 32];
      mn[bn+j] = d[32*(n-1-j) +: 32];
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) mw[i] = '0;
    for (int i = 0; i < 32; i++) mn[i] = '0;
  endtask

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, check reads (state before this write), then clock the write
  task automatic step(logic we, logic [1:0] wp, logic [4:0] wf, logic [127:0] wd,
                      logic [1:0] ap, logic [4:0] af, logic [1:0] bp, logic [4:0] bf,
                      string tag);
    @(negedge clk);
    wr_en = we; wr_prec = wp; wr_fld = wf; wr_data = wd;
    rd0_prec = ap; rd0_fld = af; rd1_prec = bp; rd1_fld = bf;
    #1;
    check(tag, "wide rd0", w_rd0, model_read(1'b1, ap, af));
    check(tag, "wide rd1", w_rd1, model_read(1'b1, bp, bf));
    check(tag, "narrow rd0", n_rd0, model_read(1'b0, ap, af));
    check(tag, "narrow rd1", n_rd1, model_read(1'b0, bp, bf));
    @(posedge clk);
    if (we) model_write(wp, wf, wd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_prec = '0; wr_fld = '0; wr_data = '0;
    rd0_prec = '0; rd0_fld = '0; rd1_prec = '0; rd1_fld = '0;
    do_reset();

    // R1: cleared after reset
    step(0, 2'd0, 5'd0, '0, 2'd2, 5'd0, 2'd2, 5'd1, "R1");
    step(0, 2'd0, 5'd0, '0, 2'd2, 5'd12, 2'd1, 5'd31, "R1");

    // R2 and R9: single write, same-cycle read old, next cycle new
    step(1, 2'd0, 5'd5, 128'h0123_4567_89ab_cdef_0000_0000_dead_beef,
         2'd0, 5'd5, 2'd0, 5'd5, "R9");
    step(0, 2'd0, 5'd0, '0, 2'd0, 5'd5, 2'd1, 5'd4, "R2");

    // R6: wide double field 3 -> words 34,35; narrow -> words 2,3
    step(1, 2'd1, 5'd3, 128'h0_0000_0000_1111_2222_3333_4444,
         2'd1, 5'd3, 2'd2, 5'd3, "R6");
    step(0, 2'd0, 5'd0, '0, 2'd2, 5'd3, 2'd1, 5'd3, "R6");
    // R5, R8: narrow singles 2 and 3 hold the halves; field 2 reads the same double
    step(0, 2'd0, 5'd0, '0, 2'd0, 5'd2, 2'd0, 5'd3, "R8");
    step(0, 2'd0, 5'd0, '0, 2'd1, 5'd2, 2'd2, 5'd1, "R5");

    // R4: quad write field 9 (wide -> 40..43, narrow -> 8..11)
    step(1, 2'd2, 5'd9, 128'haaaa_0001_bbbb_0002_cccc_0003_dddd_0004,
         2'd2, 5'd9, 2'd0, 5'd8, "R4");
    step(0, 2'd0, 5'd0, '0, 2'd2, 5'd9, 2'd0, 5'd10, "R4");
    step(0, 2'd0, 5'd0, '0, 2'd1, 5'd9, 2'd1, 5'd10, "R4");

    // R7: wide single 31 is word 31, seen by double field 30; double field 31 is words 62,63
    step(1, 2'd0, 5'd31, 128'h7777_8888, 2'd0, 5'd31, 2'd1, 5'd30, "R7");
    step(0, 2'd0, 5'd0, '0, 2'd1, 5'd30, 2'd1, 5'd31, "R7");

    // R10: reserved write ignored, reserved read zero
    step(1, 2'd3, 5'd5, rnd128(), 2'd3, 5'd5, 2'd3, 5'd9, "R10");
    step(0, 2'd0, 5'd0, '0, 2'd0, 5'd5, 2'd3, 5'd9, "R10");

    // R11: write enable low changes nothing
    step(0, 2'd2, 5'd9, rnd128(), 2'd2, 5'd9, 2'd0, 5'd5, "R11");
    step(0, 2'd0, 5'd0, '0, 2'd2, 5'd9, 2'd1, 5'd3, "R11");

    // random traffic with read-after-write bias
    begin
      logic [1:0] lp = 2'd0;
      logic [4:0] lf = 5'd0;
      for (int it = 0; it < 3000; it++) begin
        logic       we = ($urandom % 4) != 0;
        logic [1:0] wp = 2'($urandom % 4);
        logic [4:0] wf = 5'($urandom);
        logic [1:0] ap = ($urandom % 2) ? lp : 2'($urandom % 4);
        logic [4:0] af = ($urandom % 2) ? lf : 5'($urandom);
        d = rnd128();
        step(we, wp, wf, d, ap, af, 2'($urandom % 4), 5'($urandom), "R8");
        lp = wp; lf = wf;
      end
    end

    // R1: reset in the middle clears every word
    do_reset();
    for (int f = 0; f < 32; f += 4)
      step(0, 2'd0, 5'd0, '0, 2'd2, 5'(f), 2'd2, 5'(f + 1), "R1");
    step(0, 2'd0, 5'd0, '0, 2'd0, 5'd5, 2'd1, 5'd3, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule